// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block chooses the control-store address for the next cycle of a microcoded 8-bit processor. In every cycle it looks at the microword now being executed and at the instruction register. From these it picks one of three next addresses: the following sequential address, a target written into the microword itself, or a target formed from the opcode. The microprogram counter is a register, and its value is the control-store address output. A synchronous control-store RAM therefore begins each read on a clock edge.

Two control bits set the choice. The low bit picks where a jump target comes from: the microword's 9-bit field, or the opcode widened with zeros. The next bit decides whether that target is loaded at all, or whether the counter simply steps forward. A synchronous reset sends the counter to address zero, where the fetch routine lives. A hold input freezes the counter while a memory access waits.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `uaddr` becomes 0 after that edge.
- R2: When `rst` and `hold` are low and microword bit 1 is 0, `uaddr` becomes its previous value plus one after the edge.
- R3: Sequential stepping wraps from the top address (511 for the default 9-bit width) to 0.
- R4: When bit 1 is 1 and bit 0 is 0, `uaddr` loads microword bits 10 down to 2 (bit 2 is the LSB), and the `opcode` value has no effect.
- R5: When bits 1 and 0 are both 1, `uaddr` loads `opcode` with zeros added above it to 9 bits, and microword bits 10..2 have no effect.
- R6: When `hold` is high and `rst` is low, `uaddr` keeps its value, whatever the microword and opcode are.
- R7: Reset takes priority over hold.
- R8: Microword bits 19 down to 11 have no effect on the next address.
- R9: `uaddr` changes only at a rising clock edge. An input change between edges does not show on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Freezes the microprogram counter |
| uword | input | 20 | Microword now executing |
| opcode | input | 8 | Instruction register contents |
| uaddr | output | 9 | Registered control-store address |

## Verification
First the bench steps the counter with junk in the upper microword bits. It then jumps near the top of the address space to show the wrap, and it pairs each jump with a deliberately different opcode (and each dispatch with a different jump field). This tells apart a mux that selects the wrong source from one that selects the right one. Opcodes 0x00, 0xFF and 0xA5 test the zero-extension at both ends and with a mixed bit pattern. Hold is held high while load bits are set, and reset is raised together with hold, to confirm the priority order. A final phase runs the counter against an array that acts as a synchronous control store, filled with a mix of steps, jumps and dispatches, while hold is toggled at random.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // Bit positions inside the microword; the sequencer decodes these.
    localparam int unsigned SRC_BIT  = 0;  // 0: jump field, 1: opcode
    localparam int unsigned LOAD_BIT = 1;  // 1: load target, 0: step
    localparam int unsigned JMP_LSB  = 2;  // low bit of the jump field

    typedef enum logic [1:0] {
        NXT_STEP   = 2'd0,
        NXT_FIELD  = 2'd1,
        NXT_OPCODE = 2'd2,
        NXT_HOLD   = 2'd3
    } nxt_sel_e;

endpackage

// File: rtl/useq_field_decode.sv
module useq_field_decode
    import useq_pkg::*;
#(
    parameter int unsigned UW_W = 20,
    parameter int unsigned AW   = 9
) (
    input  logic            hold,
    input  logic [UW_W-1:0] uword,
    output nxt_sel_e        sel,
    output logic [AW-1:0]   field_addr
);

    localparam int unsigned FIELD_MSB = JMP_LSB + AW - 1;

    always_comb begin
        if (hold) begin
            sel = NXT_HOLD;
        end else if (!uword[LOAD_BIT]) begin
            sel = NXT_STEP;
        end else if (uword[SRC_BIT]) begin
            sel = NXT_OPCODE;
        end else begin
            sel = NXT_FIELD;
        end
    end

    assign field_addr = uword[FIELD_MSB:JMP_LSB];

endmodule

// File: rtl/useq_dispatch_ext.sv
module useq_dispatch_ext #(
    parameter int unsigned IR_W = 8,
    parameter int unsigned AW   = 9
) (
    input  logic [IR_W-1:0] opcode,
    output logic [AW-1:0]   disp_addr
);

    generate
        if (IR_W < AW) begin : g_widen
            localparam int unsigned PAD = AW - IR_W;
            assign disp_addr = {{PAD{1'b0}}, opcode};
        end else begin : g_trim
            assign disp_addr = opcode[AW-1:0];
        end
    endgenerate

endmodule

// File: rtl/useq_incr.sv
module useq_incr #(
    parameter int unsigned AW = 9
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);

    localparam logic [AW-1:0] ONE = AW'(1);

    assign nxt = cur + ONE;

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int unsigned UW_W = 20,
    parameter int unsigned IR_W = 8,
    parameter int unsigned AW   = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic [UW_W-1:0] uword,
    input  logic [IR_W-1:0] opcode,
    output logic [AW-1:0]   uaddr
);

    typedef struct packed {
        logic [AW-1:0] upc;
    } seq_state_t;

    seq_state_t state_d, state_q;

    nxt_sel_e      sel;
    logic [AW-1:0] field_addr;
    logic [AW-1:0] disp_addr;
    logic [AW-1:0] step_addr;

    useq_field_decode #(.UW_W(UW_W), .AW(AW)) u_decode (
        .hold       (hold),
        .uword      (uword),
        .sel        (sel),
        .field_addr (field_addr)
    );

    useq_dispatch_ext #(.IR_W(IR_W), .AW(AW)) u_dispatch (
        .opcode    (opcode),
        .disp_addr (disp_addr)
    );

    useq_incr #(.AW(AW)) u_incr (
        .cur (state_q.upc),
        .nxt (step_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (sel)
            NXT_STEP:   state_d.upc = step_addr;
            NXT_FIELD:  state_d.upc = field_addr;
            NXT_OPCODE: state_d.upc = disp_addr;
            NXT_HOLD:   state_d.upc = state_q.upc;
            default:    state_d.upc = state_q.upc;
        endcase
        if (rst) begin
            state_d.upc = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign uaddr = state_q.upc;

    // R1
    reset_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (uaddr == '0));

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(hold) && !$past(rst)) |-> $stable(uaddr));

    // R2
    step_plus_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hold) && !$past(uword[LOAD_BIT]))
        |-> (uaddr == AW'($past(uaddr) + 1'b1)));

    // R4
    field_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hold) && $past(uword[LOAD_BIT]) && !$past(uword[SRC_BIT]))
        |-> (uaddr == $past(uword[JMP_LSB +: AW])));

    // R5
    opcode_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hold) && $past(uword[LOAD_BIT]) && $past(uword[SRC_BIT]))
        |-> (uaddr == AW'($past(opcode))));

endmodule

// File: tb/useq_sequencer_bench.sv
module useq_sequencer_bench;

    localparam int UW_W  = 20;
    localparam int IR_W  = 8;
    localparam int AW    = 9;
    localparam int DEPTH = 1 << AW;

    logic            clk = 1'b0;
    logic            drv_rst = 1'b1;
    logic            drv_hold = 1'b0;
    logic [UW_W-1:0] drv_w = '0;
    logic [IR_W-1:0] drv_op = '0;
    logic            ram_mode = 1'b0;
    logic [UW_W-1:0] ram_q = '0;
    logic [UW_W-1:0] mem [DEPTH];
    logic [UW_W-1:0] uword;
    logic [AW-1:0]   uaddr;

    int checks = 0;
    int errors = 0;
    int exp_addr = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign uword = ram_mode ? ram_q : drv_w;

    // Synchronous control-store model
    always @(posedge clk) ram_q <= mem[uaddr];

    useq_sequencer u_useq_sequencer (
        .clk    (clk),
        .rst    (drv_rst),
        .hold   (drv_hold),
        .uword  (uword),
        .opcode (drv_op),
        .uaddr  (uaddr)
    );

    function automatic int model_next(int cur, bit r, bit h, logic [UW_W-1:0] w,
                                      logic [IR_W-1:0] op);
        if (r) return 0;
        if (h) return cur;
        if (w[1] == 1'b0) return (cur + 1) % DEPTH;
        if (w[0] == 1'b1) return int'(op);
        return int'(w[10:2]);
    endfunction

    task automatic check(string tag);
        checks++;
        if (int'(uaddr) != exp_addr) begin
            errors++;
            $display("FAIL %s uaddr actual=%0d expected=%0d", tag, uaddr, exp_addr);
        end
    endtask

    // Drive one cycle from a falling edge, then compare at the next falling edge.
    task automatic cyc(bit r, bit h, logic [UW_W-1:0] w, logic [IR_W-1:0] op, string tag);
        drv_rst  = r;
        drv_hold = h;
        drv_w    = w;
        drv_op   = op;
        #1;
        exp_addr = model_next(exp_addr, r, h, uword, op);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    function automatic logic [UW_W-1:0] mk(bit ld, bit src, int tgt);
        logic [UW_W-1:0] w;
        w        = UW_W'($urandom);
        w[0]     = src;
        w[1]     = ld;
        w[10:2]  = 9'(tgt);
        return w;
    endfunction

    initial begin
        @(negedge clk);
        // R1: reset state
        cyc(1, 0, mk(1, 0, 77), 8'h33, "R1");
        cyc(1, 0, mk(0, 0, 5), 8'h10, "R1");

        // R2 / R8: stepping with junk in upper bits
        for (int i = 0; i < 6; i++) cyc(0, 0, mk(0, i[0], 300 + i), 8'(i * 29), "R2_R8");

        // R4: jump near the top, R3: wrap
        cyc(0, 0, mk(1, 0, 510), 8'h5A, "R4");
        cyc(0, 0, mk(0, 1, 3), 8'h00, "R3");
        cyc(0, 0, mk(0, 0, 3), 8'h00, "R3");
        cyc(0, 0, mk(0, 0, 3), 8'h00, "R2");

        // R4: jump field with a different opcode present
        cyc(0, 0, mk(1, 0, 291), 8'hC3, "R4");
        cyc(0, 0, mk(1, 0, 0), 8'hFF, "R4");

        // R5: dispatch, extremes and a mixed pattern
        cyc(0, 0, mk(1, 1, 400), 8'hFF, "R5");
        cyc(0, 0, mk(1, 1, 17), 8'h00, "R5");
        cyc(0, 0, mk(1, 1, 511), 8'hA5, "R5");

        // R8: upper bits all ones do not disturb a jump
        cyc(0, 0, {9'h1FF, 9'd123, 2'b10}, 8'h44, "R8");

        // R6: hold beats jump, dispatch and step
        cyc(0, 1, mk(1, 0, 9), 8'h01, "R6");
        cyc(0, 1, mk(1, 1, 9), 8'h7E, "R6");
        cyc(0, 1, mk(0, 0, 9), 8'h7E, "R6");
        cyc(0, 0, mk(0, 0, 9), 8'h7E, "R2");

        // R7: reset beats hold
        cyc(1, 1, mk(1, 0, 200), 8'h11, "R7");
        cyc(0, 0, mk(1, 0, 200), 8'h11, "R4");

        // R9: input change between edges is not seen
        drv_w = mk(1, 0, 85);
        drv_op = 8'h99;
        #2;
        check("R9");
        cyc(0, 0, mk(0, 0, 1), 8'h00, "R2");

        // Control-store phase: steps, jumps and dispatches (R2, R4, R5, R6)
        for (int i = 0; i < DEPTH; i++) begin
            if (i % 7 == 3)       mem[i] = mk(1, 0, (i * 37) % DEPTH);
            else if (i % 11 == 5) mem[i] = mk(1, 1, 0);
            else                  mem[i] = mk(0, 0, 0);
        end
        cyc(1, 0, '0, 8'h00, "R1");
        ram_mode = 1'b1;
        for (int i = 0; i < 120; i++)
            cyc(0, ($urandom % 4) == 0, '0, 8'($urandom), "R2_R4_R5_R6");
        ram_mode = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule